// File: doc/BRIEF.md
# Secured Scan Test Port

This block is a test access port for board-level and internal scan test. A five-bit instruction register chooses which data register sits between the serial input and the serial output. The choices are a fixed 32-bit identification word, a one-bit bypass stage, or a boundary chain. The chain holds one cell for every pad input and one for every pad output. Each cell can capture, shift, and drive an update latch. Depending on the instruction, that latch either overrides the pads or overrides the signals the core receives.

Two status inputs gate the chain instructions: a security fuse and an indication that the flash controller is held in reset. While either one applies, the sample, external-test and internal-test opcodes act like bypass, and the pads stay in functional mode. The identification instruction is never blocked. Loading the erase opcode clears the fuse lock until the next port reset. The flash-reset lock cannot be cleared by an erase.

Top module: `scan_tap_guard`

## Requirements
- R1: The controller state moves on the rising edge of `tck`. `tap_rst` high, or five rising edges with `tms` high, puts the port into its reset state. In the reset state the instruction is the identification opcode 0x01.
- R2: On every instruction capture, the instruction shift stage loads the pattern 5'b00001. It then shifts least significant bit first, entering from `tdi` and leaving at `tdo`.
- R3: Under the identification opcode, a data scan returns the 32-bit word {VERSION[3:0], PART[15:0], MAKER[10:0], 1'b1}, least significant bit first.
- R4: The all-ones opcode 0x1F, the erase opcode 0x0F and any undefined opcode select a one-bit bypass stage. This stage captures 0, so the bits that come out are the bits that went in, delayed by one.
- R5: Under the sample opcode 0x02, a data capture loads the pad inputs into chain bits [PINS-1:0] and the core outputs into bits [2*PINS-1:PINS]. The pads and the core inputs keep their functional values, even after an update.
- R6: Under the external-test opcode 0x03, `pad_tx` shows the output half of the update latch from the moment the opcode is latched. Capture loads the pad inputs and the driven pad values.
- R7: Under the internal-test opcode 0x04, `core_rx` shows the input half of the update latch and `pad_tx` shows the output half. Capture loads the core outputs into the output half.
- R8: While `fuse_set` is high and no erase has been latched, opcodes 0x02 to 0x04 behave as bypass and `pad_tx` follows `core_tx`. The identification opcode still works.
- R9: Latching the erase opcode 0x0F lifts the fuse lock until the next `tap_rst`.
- R10: While `flash_rst` is high, opcodes 0x02 to 0x04 are blocked whether or not an erase has been done. The pads return to functional values in the same cycle.
- R11: `tdo` changes on the falling edge of `tck`. `tdo_oe` is high only while the port is in an instruction-shift or data-shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high port reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | High when `tdo` is valid and should be driven |
| pad_in | input | PINS | Values arriving on the input pads |
| pad_tx | output | PINS | Values sent to the output pads |
| core_tx | input | PINS | Values the core wants on the output pads |
| core_rx | output | PINS | Values delivered to the core from the input pads |
| fuse_set | input | 1 | Security fuse programmed |
| flash_rst | input | 1 | Flash controller held in reset |

## Verification
The hardest case to reach is a chain instruction that is already in force when a lock input changes. The pads must fall back to functional values at once, with no scan in flight, and must come back once the erase and lock conditions allow. To get there, the stimulus first leaves a known pattern in the update latch with an internal-test scan. It then raises the fuse input while that opcode is still latched, and checks the pads before any further scan. After that it loads the erase opcode and then external test, and finally toggles the flash-reset input. Each time it checks that the same update-latch value reappears on the pads.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 5;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_IDCODE  = 5'h01;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 5'h02;
    localparam logic [IR_W-1:0] OP_EXTEST  = 5'h03;
    localparam logic [IR_W-1:0] OP_INTEST  = 5'h04;
    localparam logic [IR_W-1:0] OP_ERASE   = 5'h0F;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

    typedef enum logic [1:0] {DR_ID, DR_BYP, DR_CHAIN} dr_sel_e;
    typedef enum logic [1:0] {PM_FUNC, PM_SAMPLE, PM_EXTEST, PM_INTEST} pin_mode_e;

    typedef struct packed {
        dr_sel_e   dr;
        pin_mode_e mode;
    } decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic decode_t decode_op(input logic [IR_W-1:0] op, input logic locked);
        decode_t d;
        d.dr   = DR_BYP;
        d.mode = PM_FUNC;
        case (op)
            OP_IDCODE: d.dr = DR_ID;
            OP_SAMPLE: if (!locked) begin d.dr = DR_CHAIN; d.mode = PM_SAMPLE; end
            OP_EXTEST: if (!locked) begin d.dr = DR_CHAIN; d.mode = PM_EXTEST; end
            OP_INTEST: if (!locked) begin d.dr = DR_CHAIN; d.mode = PM_INTEST; end
            default:   d.dr = DR_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    input  logic       fuse_set,
    input  logic       flash_rst,
    output logic       ir_tdo,
    output logic       locked,
    output decode_t    dec
);
    logic [IR_W-1:0] ir_sh, ir_q;
    logic            erased;

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) begin
            ir_q  <= OP_IDCODE;
            ir_sh <= IR_CAPTURE;
        end else begin
            case (state)
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sh;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst)                                      erased <= 1'b0;
        else if (state == ST_UPD_IR && ir_sh == OP_ERASE) erased <= 1'b1;
    end

    assign locked = flash_rst | (fuse_set & ~erased);
    assign dec    = decode_op(ir_q, locked);
    assign ir_tdo = ir_sh[0];

    p_ir_reset_r1: assert property (@(posedge tck) disable iff (rst)
        state == ST_RESET |=> ir_q == OP_IDCODE);
    p_capture_pat_r2: assert property (@(posedge tck) disable iff (rst)
        state == ST_CAP_IR |=> ir_sh == IR_CAPTURE);
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import scan_tap_pkg::*;
#(
    parameter int PINS = 4
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  decode_t         dec,
    input  logic            tdi,
    input  logic [PINS-1:0] pad_in,
    input  logic [PINS-1:0] core_tx,
    output logic [PINS-1:0] pad_tx,
    output logic [PINS-1:0] core_rx,
    output logic            chain_tdo
);
    localparam int CW = 2 * PINS;

    logic [CW-1:0] sh, upd, cap;
    logic          sel, drive_pads;

    assign sel        = (dec.dr == DR_CHAIN);
    assign drive_pads = (dec.mode == PM_EXTEST) || (dec.mode == PM_INTEST);

    for (genvar g = 0; g < PINS; g++) begin : g_cell
        assign cap[g]        = pad_in[g];
        assign cap[PINS+g]   = (dec.mode == PM_EXTEST) ? upd[PINS+g] : core_tx[g];
        assign pad_tx[g]     = drive_pads ? upd[PINS+g] : core_tx[g];
        assign core_rx[g]    = (dec.mode == PM_INTEST) ? upd[g] : pad_in[g];
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            sh  <= '0;
            upd <= '0;
        end else if (sel) begin
            case (state)
                ST_CAP_DR: sh  <= cap;
                ST_SH_DR:  sh  <= {tdi, sh[CW-1:1]};
                ST_UPD_DR: upd <= sh;
                default:   ;
            endcase
        end
    end

    assign chain_tdo = sh[0];

    p_update_latch_r6: assert property (@(posedge tck) disable iff (rst)
        (sel && state == ST_UPD_DR) |=> upd == $past(sh));
endmodule

// File: rtl/scan_tap_guard.sv
module scan_tap_guard
    import scan_tap_pkg::*;
#(
    parameter int          PINS    = 4,
    parameter logic [3:0]  VERSION = 4'h3,
    parameter logic [15:0] PART    = 16'h5A17,
    parameter logic [10:0] MAKER   = 11'h0AB
) (
    input  logic            tck,
    input  logic            tap_rst,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_tx,
    input  logic [PINS-1:0] core_tx,
    output logic [PINS-1:0] core_rx,
    input  logic            fuse_set,
    input  logic            flash_rst
);
    localparam logic [31:0] ID_WORD = {VERSION, PART, MAKER, 1'b1};

    tap_state_e  state;
    decode_t     dec;
    logic        locked, ir_tdo, chain_tdo, byp_q, tdo_mux;
    logic [31:0] id_sh;

    tap_fsm u_fsm (.tck(tck), .rst(tap_rst), .tms(tms), .state(state));

    tap_ir u_ir (
        .tck(tck), .rst(tap_rst), .state(state), .tdi(tdi),
        .fuse_set(fuse_set), .flash_rst(flash_rst),
        .ir_tdo(ir_tdo), .locked(locked), .dec(dec)
    );

    bscan_chain #(.PINS(PINS)) u_chain (
        .tck(tck), .rst(tap_rst), .state(state), .dec(dec), .tdi(tdi),
        .pad_in(pad_in), .core_tx(core_tx), .pad_tx(pad_tx), .core_rx(core_rx),
        .chain_tdo(chain_tdo)
    );

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            id_sh <= '0;
            byp_q <= 1'b0;
        end else begin
            if (dec.dr == DR_ID) begin
                if (state == ST_CAP_DR)     id_sh <= ID_WORD;
                else if (state == ST_SH_DR) id_sh <= {tdi, id_sh[31:1]};
            end
            if (dec.dr == DR_BYP) begin
                if (state == ST_CAP_DR)     byp_q <= 1'b0;
                else if (state == ST_SH_DR) byp_q <= tdi;
            end
        end
    end

    always_comb begin
        if (state == ST_SH_IR) tdo_mux = ir_tdo;
        else begin
            case (dec.dr)
                DR_ID:    tdo_mux = id_sh[0];
                DR_CHAIN: tdo_mux = chain_tdo;
                default:  tdo_mux = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_mux;
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    p_oe_shift_r11: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
    p_locked_pins_r8: assert property (@(posedge tck) disable iff (tap_rst)
        locked |-> pad_tx == core_tx);
    p_flash_lock_r10: assert property (@(posedge tck) disable iff (tap_rst)
        flash_rst |-> (pad_tx == core_tx && core_rx == pad_in));
    p_bypass_capture_r4: assert property (@(posedge tck) disable iff (tap_rst)
        (state == ST_CAP_DR && dec.dr == DR_BYP) |=> byp_q == 1'b0);
endmodule

// File: tb/scan_tap_guard_tb_top.sv
module scan_tap_guard_tb_top;
    import scan_tap_pkg::*;

    localparam int          PINS = 4;
    localparam logic [3:0]  VER  = 4'h3;
    localparam logic [15:0] PRT  = 16'h5A17;
    localparam logic [10:0] MKR  = 11'h0AB;
    localparam logic [31:0] ID_EXP = {VER, PRT, MKR, 1'b1};

    logic tck = 1'b0;
    always #4 tck = ~tck;

    logic tap_rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe;
    logic [PINS-1:0] pad_in = '0, core_tx = '0, pad_tx, core_rx;
    logic fuse_set = 1'b0, flash_rst = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic oe_seen;
    logic [31:0] r;
    bit done = 0;

    scan_tap_guard #(.PINS(PINS), .VERSION(VER), .PART(PRT), .MAKER(MKR)) dut_i (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .pad_in(pad_in), .pad_tx(pad_tx), .core_tx(core_tx), .core_rx(core_rx),
        .fuse_set(fuse_set), .flash_rst(flash_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic s);
        @(negedge tck);
        #1;
        s   = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic scan(input bit ir, input int n, input logic [31:0] din, output logic [31:0] dout);
        logic s;
        dout = '0;
        oe_seen = 1'b1;
        step(1'b1, 1'b0, s);
        if (ir) step(1'b1, 1'b0, s);
        step(1'b0, 1'b0, s);
        step(1'b0, 1'b0, s);
        for (int k = 0; k < n; k++) begin
            step(k == n - 1, din[k], s);
            dout[k] = s;
            oe_seen = oe_seen & tdo_oe;
        end
        step(1'b1, 1'b0, s);
        step(1'b0, 1'b0, s);
        step(1'b0, 1'b0, s);
    endtask

    task automatic load_ir(input logic [IR_W-1:0] op);
        logic [31:0] d;
        scan(1'b1, IR_W, {27'd0, op}, d);
    endtask

    task automatic t_reset();
        logic s;
        tap_rst = 1'b1;
        repeat (2) @(negedge tck);
        tap_rst = 1'b0;
        #1;
        chk("R11 tdo_oe low after reset", tdo_oe, 1'b0);
        chk("R1 pads functional in reset", pad_tx, core_tx);
        step(1'b0, 1'b0, s);
        step(1'b0, 1'b0, s);
        scan(1'b0, 32, 32'h0, r);
        chk("R3 R1 default IDCODE word", r, ID_EXP);
        chk("R3 ID bit0 fixed one", r[0], 1'b1);
        chk("R11 tdo_oe high while shifting", oe_seen, 1'b1);
        chk("R11 tdo_oe low in idle", tdo_oe, 1'b0);
    endtask

    task automatic t_ir_bypass();
        scan(1'b1, IR_W, {27'd0, OP_BYPASS}, r);
        chk("R2 IR capture pattern", r[4:0], 5'b00001);
        scan(1'b0, 8, 32'hA5, r);
        chk("R4 bypass all-ones delay", r[7:0], 8'h4A);
        load_ir(5'h1B);
        scan(1'b0, 8, 32'h3C, r);
        chk("R4 bypass unknown opcode", r[7:0], 8'h78);
    endtask

    task automatic t_tms_reset();
        logic s;
        load_ir(OP_SAMPLE);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, s);
        step(1'b0, 1'b0, s);
        step(1'b0, 1'b0, s);
        scan(1'b0, 32, 32'h0, r);
        chk("R1 TMS reset restores IDCODE", r, ID_EXP);
    endtask

    task automatic t_sample();
        pad_in  = 4'b1010;
        core_tx = 4'b0110;
        load_ir(OP_SAMPLE);
        scan(1'b0, 8, 32'h3C, r);
        chk("R5 sample capture", r[7:0], 8'h6A);
        chk("R5 pads not driven by latch", pad_tx, core_tx);
        chk("R5 core inputs untouched", core_rx, pad_in);
    endtask

    task automatic t_extest();
        load_ir(OP_EXTEST);
        chk("R6 pads from latch on opcode load", pad_tx, 4'h3);
        scan(1'b0, 8, 32'hC5, r);
        chk("R6 extest capture", r[7:0], 8'h3A);
        chk("R6 pads after update", pad_tx, 4'hC);
    endtask

    task automatic t_intest();
        load_ir(OP_INTEST);
        chk("R7 core inputs from latch", core_rx, 4'h5);
        chk("R7 pads from latch", pad_tx, 4'hC);
        scan(1'b0, 8, 32'h9E, r);
        chk("R7 intest capture", r[7:0], 8'h6A);
        chk("R7 core inputs after update", core_rx, 4'hE);
        chk("R7 pads after update", pad_tx, 4'h9);
    endtask

    task automatic t_fuse();
        fuse_set = 1'b1;
        #1;
        chk("R8 fuse releases pads at once", pad_tx, core_tx);
        chk("R8 fuse releases core inputs", core_rx, pad_in);
        load_ir(OP_EXTEST);
        scan(1'b0, 8, 32'h5A, r);
        chk("R8 blocked extest is bypass", r[7:0], 8'hB4);
        chk("R8 pads functional when blocked", pad_tx, core_tx);
        load_ir(OP_IDCODE);
        scan(1'b0, 32, 32'h0, r);
        chk("R8 IDCODE allowed when locked", r, ID_EXP);
    endtask

    task automatic t_erase();
        load_ir(OP_ERASE);
        scan(1'b0, 8, 32'h81, r);
        chk("R4 R9 erase opcode selects bypass", r[7:0], 8'h02);
        load_ir(OP_EXTEST);
        chk("R9 extest restored after erase", pad_tx, 4'h9);
        scan(1'b0, 8, 32'h71, r);
        chk("R9 extest capture after erase", r[7:0], 8'h9A);
        chk("R9 pads updated after erase", pad_tx, 4'h7);
    endtask

    task automatic t_flash();
        flash_rst = 1'b1;
        #1;
        chk("R10 flash reset releases pads", pad_tx, core_tx);
        scan(1'b0, 8, 32'h0F, r);
        chk("R10 flash reset forces bypass", r[7:0], 8'h1E);
        flash_rst = 1'b0;
        #1;
        chk("R10 R9 pads return after flash reset", pad_tx, 4'h7);
    endtask

    initial begin
        t_reset();
        t_ir_bypass();
        t_tms_reset();
        t_sample();
        t_extest();
        t_intest();
        t_fuse();
        t_erase();
        t_flash();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule